// File: doc/BRIEF.md
# Fixed-Frequency Winding Current Regulator with Automatic Decay Selection

This block closes the digital part of the current loop for one H-bridge winding. An analog comparator outside the block reports one bit: whether the winding current magnitude is at or above the requested level. From that bit and a signed set-point, the block decides each clock cycle whether the bridge drives the winding forward, recirculates in slow decay, or reverses in fast decay. The bridge controls are registered, so every switching point falls on a clock edge.

The regulation period is a fixed count of clock cycles. It does not depend on supply or load. A control input halves the period, which doubles the switching frequency. A second input adds a pseudo-random length offset to each period, which spreads the emission spectrum.

In steady state a period begins in forward drive and falls back to slow decay once the comparator trips. Forward drive may therefore fill most of a period when the back-EMF is high. The set-point is captured only at period boundaries. When the captured value asks for less current than before, the next period opens in fast decay. Fast decay holds until the comparator reports that the current has fallen below the new target.

Top module: `pwm_current_reg`

## Requirements
- R1: While `rst` is high and on the first edge it is seen high, all three bridge controls, `period_start` and `setpt_act` are 0. The first period begins on the first clock edge with `rst` low, so `period_start` is 1 in the cycle that follows.
- R2: With `dbl_freq` = 0 and `jit_en` = 0 at a boundary, the period that starts there lasts PERIOD cycles (default 175). `period_start` is high only in the first cycle of each period.
- R3: With `dbl_freq` = 1 and `jit_en` = 0 at a boundary, the period lasts PERIOD/2 cycles, rounded down (87 by default).
- R4: An 8-bit shift register is seeded with 0xA5 on reset. At every period boundary it shifts left, and the new bit 0 is the XOR of the old bits 7, 5, 4 and 3. With `jit_en` = 1, the period starting at that boundary gets an offset added to its length. The offset is the low 5 bits of the shifted value minus 16. When `dbl_freq` = 1, the offset is first shifted right arithmetically by one, rounding toward minus infinity.
- R5: A period that does not open in fast decay opens in forward drive. Slow decay follows in the cycle after the first cycle in which `cmp_hi` is 1 during forward drive, and it holds to the end of the period. If `cmp_hi` stays 0, forward drive lasts the whole period.
- R6: `setpt` is sampled only in the last cycle of a period. `setpt_act` and `polarity_neg` change only in a cycle where `period_start` is 1. `polarity_neg` is the sign bit of `setpt_act` (1 means negative).
- R7: A drop opens the next period in fast decay. A drop is either a sampled magnitude lower than the active magnitude, or a sign reversal from a nonzero active value. Fast decay continues while `cmp_hi` is 1, across period boundaries as well. In the cycle after `cmp_hi` is seen 0, forward drive takes over.
- R8: A sampled set-point of equal or larger magnitude with the same sign does not produce fast decay.
- R9: At most one of `fwd_on`, `slow_on` and `fast_on` is 1 in any cycle, and forward drive and fast decay are never both 1.
- R10: In the cycle after `en` is sampled 0, all bridge controls are 0. They stay 0 until the next period start with `en` at 1, and that period opens in forward drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all switching points align to it |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Bridge enable; 0 forces all controls off |
| dbl_freq | input | 1 | Halve the period length |
| jit_en | input | 1 | Add pseudo-random period offset |
| cmp_hi | input | 1 | Comparator: winding current at or above target |
| setpt | input | SP_W | Signed current set-point (two's complement) |
| fwd_on | output | 1 | Forward drive phase |
| slow_on | output | 1 | Slow decay (recirculation) phase |
| fast_on | output | 1 | Fast decay (reverse) phase |
| polarity_neg | output | 1 | Sign of the active set-point, selects bridge direction |
| setpt_act | output | SP_W | Set-point in force for the current period |
| period_start | output | 1 | High in the first cycle of each period |

## Verification
The hardest case to reach from the ports is fast decay carried across a period boundary. The comparator has to stay high through a boundary, after a drop was captured at the previous boundary. Separately, jittered period lengths depend on how many boundaries have passed since reset. The stimulus first synchronises on `period_start`. It then changes the set-point and the comparator a fixed number of cycles into a period, so the bench knows which boundary samples each change. A scoreboard counts boundaries and predicts each period length from the shift-register rule in R4.

// File: rtl/pwm_reg_pkg.sv
`timescale 1ns/1ps
package pwm_reg_pkg;
  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_FWD  = 2'd1,
    PH_SLOW = 2'd2,
    PH_FAST = 2'd3
  } phase_e;
endpackage

// File: rtl/pwm_period_gen.sv
`timescale 1ns/1ps
// Period timer: down-counter reloaded at each boundary with a length
// chosen from the base count, the halving control and the jitter offset.
module pwm_period_gen #(
  parameter int          PERIOD   = 175,
  parameter int          LFSR_W   = 8,
  parameter logic [7:0]  TAPS     = 8'hB8,
  parameter logic [7:0]  SEED     = 8'hA5,
  parameter int          JIT_BITS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic dbl_i,
  input  logic jit_i,
  output logic last_o,
  output logic start_o
);
  localparam int HALF  = PERIOD / 2;
  localparam int JHALF = 2 ** (JIT_BITS - 1);
  localparam int CNT_W = $clog2(PERIOD + 2 * JHALF + 1);

  logic [CNT_W-1:0]  cnt;
  logic [LFSR_W-1:0] lfsr, lfsr_nxt;
  int base, off, len;

  assign lfsr_nxt = {lfsr[LFSR_W-2:0], ^(lfsr & TAPS[LFSR_W-1:0])};
  assign last_o   = (cnt == '0);

  always_comb begin
    base = dbl_i ? HALF : PERIOD;
    off  = int'(lfsr_nxt[JIT_BITS-1:0]) - JHALF;
    if (dbl_i) off = off >>> 1;
    if (!jit_i) off = 0;
    len  = base + off;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      lfsr    <= SEED[LFSR_W-1:0];
      start_o <= 1'b0;
    end else begin
      start_o <= last_o;
      if (last_o) begin
        cnt  <= CNT_W'(len - 1);
        lfsr <= lfsr_nxt;
      end else begin
        cnt  <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_setpt_track.sv
`timescale 1ns/1ps
// Holds the set-point in force and flags a request for less current.
module pwm_setpt_track #(
  parameter int SP_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [SP_W-1:0] sp_i,
  output logic [SP_W-1:0] sp_o,
  output logic            drop_o
);
  logic signed [SP_W:0] new_ext, old_ext;
  logic        [SP_W:0] new_mag, old_mag;
  logic                 sign_flip;

  always_comb begin
    new_ext   = {sp_i[SP_W-1], sp_i};
    old_ext   = {sp_o[SP_W-1], sp_o};
    new_mag   = (new_ext < 0) ? -new_ext : new_ext;
    old_mag   = (old_ext < 0) ? -old_ext : old_ext;
    sign_flip = (sp_i[SP_W-1] != sp_o[SP_W-1]) && (sp_o != '0);
    drop_o    = (new_mag < old_mag) || sign_flip;
  end

  always_ff @(posedge clk) begin
    if (rst)         sp_o <= '0;
    else if (load_i) sp_o <= sp_i;
  end
endmodule

// File: rtl/pwm_phase_fsm.sv
`timescale 1ns/1ps
// Chooses the bridge phase for the next cycle; outputs are flops.
module pwm_phase_fsm
  import pwm_reg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic cmp_hi_i,
  input  logic last_i,
  input  logic drop_i,
  output logic fwd_o,
  output logic slow_o,
  output logic fast_o
);
  phase_e ph, ph_nxt;

  always_comb begin
    ph_nxt = ph;
    if (!en_i) begin
      ph_nxt = PH_OFF;
    end else if (last_i) begin
      if (drop_i)                        ph_nxt = PH_FAST;
      else if (ph == PH_FAST && cmp_hi_i) ph_nxt = PH_FAST;
      else                               ph_nxt = PH_FWD;
    end else begin
      unique case (ph)
        PH_FWD:  ph_nxt = cmp_hi_i ? PH_SLOW : PH_FWD;
        PH_FAST: ph_nxt = cmp_hi_i ? PH_FAST : PH_FWD;
        PH_SLOW: ph_nxt = PH_SLOW;
        default: ph_nxt = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_OFF;
      fwd_o  <= 1'b0;
      slow_o <= 1'b0;
      fast_o <= 1'b0;
    end else begin
      ph     <= ph_nxt;
      fwd_o  <= (ph_nxt == PH_FWD);
      slow_o <= (ph_nxt == PH_SLOW);
      fast_o <= (ph_nxt == PH_FAST);
    end
  end
endmodule

// File: rtl/pwm_current_reg.sv
`timescale 1ns/1ps
module pwm_current_reg #(
  parameter int         PERIOD    = 175,
  parameter int         SP_W      = 8,
  parameter int         LFSR_W    = 8,
  parameter logic [7:0] LFSR_TAPS = 8'hB8,
  parameter logic [7:0] LFSR_SEED = 8'hA5,
  parameter int         JIT_BITS  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            dbl_freq,
  input  logic            jit_en,
  input  logic            cmp_hi,
  input  logic [SP_W-1:0] setpt,
  output logic            fwd_on,
  output logic            slow_on,
  output logic            fast_on,
  output logic            polarity_neg,
  output logic [SP_W-1:0] setpt_act,
  output logic            period_start
);
  logic last, drop;

  pwm_period_gen #(
    .PERIOD(PERIOD), .LFSR_W(LFSR_W), .TAPS(LFSR_TAPS),
    .SEED(LFSR_SEED), .JIT_BITS(JIT_BITS)
  ) u_period (
    .clk(clk), .rst(rst), .dbl_i(dbl_freq), .jit_i(jit_en),
    .last_o(last), .start_o(period_start)
  );

  pwm_setpt_track #(.SP_W(SP_W)) u_setpt (
    .clk(clk), .rst(rst), .load_i(last), .sp_i(setpt),
    .sp_o(setpt_act), .drop_o(drop)
  );

  pwm_phase_fsm u_fsm (
    .clk(clk), .rst(rst), .en_i(en), .cmp_hi_i(cmp_hi),
    .last_i(last), .drop_i(drop),
    .fwd_o(fwd_on), .slow_o(slow_on), .fast_o(fast_on)
  );

  assign polarity_neg = setpt_act[SP_W-1];
endmodule

// File: rtl/pwm_current_reg_chk.sv
`timescale 1ns/1ps
module pwm_current_reg_chk #(
  parameter int SP_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic            cmp_hi,
  input logic            fwd_on,
  input logic            slow_on,
  input logic            fast_on,
  input logic            period_start,
  input logic [SP_W-1:0] setpt_act
);
  // R9
  excl_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fwd_on, slow_on, fast_on}));

  // R9
  no_fwd_fast_chk: assert property (@(posedge clk) disable iff (rst)
    !(fwd_on && fast_on));

  // R10
  disable_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !(fwd_on || slow_on || fast_on));

  // R5
  fwd_to_slow_chk: assert property (@(posedge clk) disable iff (rst)
    (fwd_on && cmp_hi && en) |=> (slow_on || period_start));

  // R5
  slow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (slow_on && en) |=> (slow_on || period_start));

  // R6
  setpt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !period_start |-> $stable(setpt_act));

  // R7
  fast_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fast_on) |-> period_start);
endmodule

bind pwm_current_reg pwm_current_reg_chk #(.SP_W(SP_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .cmp_hi(cmp_hi),
  .fwd_on(fwd_on), .slow_on(slow_on), .fast_on(fast_on),
  .period_start(period_start), .setpt_act(setpt_act)
);

// File: tb/pwm_current_reg_bench.sv
`timescale 1ns/1ps
module pwm_current_reg_bench;
  localparam int P = 175;

  logic       clk = 1'b0;
  logic       rst, en, dbl_freq, jit_en, cmp_hi;
  logic [7:0] setpt;
  logic       fwd_on, slow_on, fast_on, polarity_neg, period_start;
  logic [7:0] setpt_act;

  always #2.5 clk = ~clk;

  pwm_current_reg u_pwm_current_reg (
    .clk(clk), .rst(rst), .en(en), .dbl_freq(dbl_freq), .jit_en(jit_en),
    .cmp_hi(cmp_hi), .setpt(setpt), .fwd_on(fwd_on), .slow_on(slow_on),
    .fast_on(fast_on), .polarity_neg(polarity_neg), .setpt_act(setpt_act),
    .period_start(period_start)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Expected period length per R2, R3, R4
  function automatic int exp_len(input int n, input bit d, input bit j);
    logic [7:0] l = 8'hA5;
    int off;
    for (int i = 0; i < n; i++) l = {l[6:0], l[7] ^ l[5] ^ l[4] ^ l[3]};
    off = int'(l[4:0]) - 16;
    if (d) off = off >>> 1;
    if (!j) off = 0;
    return (d ? P / 2 : P) + off;
  endfunction

  typedef struct { int idx; int len; string req; } exp_t;
  exp_t sbq[$];

  int cyc = 0, last_cyc = 0, pidx = 0, got;
  exp_t e;

  // Monitor: measures each period and pops the matching expectation
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      chk(!(fwd_on && fast_on), "R9", int'(fast_on), 0);
      if (period_start) begin
        pidx++;
        if (pidx > 1) begin
          got = cyc - last_cyc;
          if (sbq.size() > 0 && sbq[0].idx == pidx - 1) begin
            e = sbq.pop_front();
            chk(got == e.len, e.req, got, e.len);
          end
        end
        last_cyc = cyc;
      end
    end
  end

  task automatic wait_start();
    @(negedge clk);
    while (!period_start) @(negedge clk);
    #1;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // Driver: sets a mode at a period start and queues the expected lengths
  task automatic run_cfg(input bit d, input bit j, input int k, input string req);
    int p;
    wait_start();
    dbl_freq = d;
    jit_en   = j;
    p = pidx;
    for (int i = 1; i <= k; i++) begin
      exp_t x;
      x.idx = p + i;
      x.len = exp_len(p + i, d, j);
      x.req = req;
      sbq.push_back(x);
    end
    repeat (k) wait_start();
  endtask

  initial begin
    #750000;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    n_bad++;
    finish_run();
  end

  initial begin
    rst = 1; en = 0; dbl_freq = 0; jit_en = 0; cmp_hi = 0; setpt = 8'd40;
    repeat (4) @(negedge clk);
    chk(!fwd_on && !slow_on && !fast_on, "R1", int'({fwd_on, slow_on, fast_on}), 0);
    chk(period_start == 0, "R1", int'(period_start), 0);
    chk(setpt_act == 0, "R1", int'(setpt_act), 0);
    #1; rst = 0; en = 1;
    for (int i = 1; i <= 3; i++) begin
      exp_t x;
      x.idx = i; x.len = P; x.req = "R2";
      sbq.push_back(x);
    end
    @(negedge clk);
    chk(period_start == 1, "R1", int'(period_start), 1);
    chk(fwd_on == 1, "R5", int'(fwd_on), 1);
    tick(100);
    chk(fwd_on == 1, "R5 no trip", int'(fwd_on), 1);
    while (pidx < 4) wait_start();

    // R5: trip to slow decay, hold, next period back to forward
    tick(20);
    chk(fwd_on == 1, "R5", int'(fwd_on), 1);
    cmp_hi = 1;
    @(negedge clk);
    chk(slow_on == 1 && fwd_on == 0, "R5 trip", int'(slow_on), 1);
    #1; cmp_hi = 0;
    tick(10);
    chk(slow_on == 1, "R5 hold", int'(slow_on), 1);
    wait_start();
    chk(fwd_on == 1, "R5 restart", int'(fwd_on), 1);

    run_cfg(1, 0, 3, "R3");
    run_cfg(0, 1, 6, "R4");
    run_cfg(1, 1, 6, "R4 dbl");
    run_cfg(0, 0, 1, "R2");
    wait_start();
    chk(sbq.size() == 0, "R2", sbq.size(), 0);

    // R6 / R8: rise in set-point takes effect at the boundary, no fast decay
    tick(10);
    setpt = 8'd60;
    @(negedge clk);
    chk(setpt_act == 8'd40, "R6", int'(setpt_act), 40);
    wait_start();
    chk(setpt_act == 8'd60, "R6", int'(setpt_act), 60);
    chk(polarity_neg == 0, "R6", int'(polarity_neg), 0);
    chk(fast_on == 0 && fwd_on == 1, "R8", int'(fast_on), 0);

    // R7: drop in magnitude
    tick(10);
    setpt = 8'd20; cmp_hi = 1;
    wait_start();
    chk(fast_on == 1, "R7 drop", int'(fast_on), 1);
    chk(setpt_act == 8'd20, "R6", int'(setpt_act), 20);
    tick(30);
    chk(fast_on == 1, "R7 hold", int'(fast_on), 1);
    wait_start();
    chk(fast_on == 1, "R7 across boundary", int'(fast_on), 1);
    tick(5);
    cmp_hi = 0;
    @(negedge clk);
    chk(fwd_on == 1 && fast_on == 0, "R7 exit", int'(fwd_on), 1);
    #1; cmp_hi = 1;
    @(negedge clk);
    chk(slow_on == 1, "R5", int'(slow_on), 1);

    // R7: sign reversal
    #1; cmp_hi = 0;
    tick(5);
    setpt = 8'hF6; cmp_hi = 1;
    wait_start();
    chk(fast_on == 1, "R7 reversal", int'(fast_on), 1);
    chk(polarity_neg == 1, "R6", int'(polarity_neg), 1);
    chk(int'($signed(setpt_act)) == -10, "R6", int'($signed(setpt_act)), -10);
    cmp_hi = 0;
    @(negedge clk);
    chk(fwd_on == 1, "R7 exit", int'(fwd_on), 1);

    // R8: equal set-point
    wait_start();
    chk(fast_on == 0 && fwd_on == 1, "R8 equal", int'(fast_on), 0);

    // R10: disable
    tick(10);
    en = 0;
    @(negedge clk);
    chk(!fwd_on && !slow_on && !fast_on, "R10 off", int'({fwd_on, slow_on, fast_on}), 0);
    tick(5);
    en = 1;
    @(negedge clk);
    chk(!fwd_on && !slow_on && !fast_on, "R10 stay off", int'({fwd_on, slow_on, fast_on}), 0);
    wait_start();
    chk(fwd_on == 1, "R10 resume", int'(fwd_on), 1);

    tick(5);
    finish_run();
  end
endmodule